// File: doc/BRIEF.md
# Pin Port Controller with Atomic Output Bit Operations

This block drives and samples a 32-pin general-purpose port. A bus master reaches six word registers through a plain address, write-enable, read-enable and data interface. Two of them hold state the master can read and write: the output latch and the per-pin direction mask. Three alias addresses change chosen bits of the output latch in one write. One alias sets bits, one clears bits and one inverts bits. The master does not need a read-modify-write sequence, so no other agent can slip a change in between.

A read-only register reports the pin levels. Each pin passes through a first flop stage. It is then captured in the input register, but only while the port-enable input is high and only for pins whose digital-function mask bit is set. Pins that are masked off read as 0. When port-enable is low, the input register keeps its last value. The pins see the output latch and an output-enable vector that is taken directly from the direction register.

Top module: `pio_port`

## Requirements
- R1: After reset the output latch, the direction register and the input register are all 0. So `pin_out` and `pin_oe` are 0 and every register reads 0x00000000.
- R2: A write to offset 0x00 replaces all 32 output bits on the clock edge where `bus_we` is high. A read of 0x00 returns the latch, and `pin_out` follows it.
- R3: A write to offset 0x04 sets to 1 each output bit whose written bit is 1, and leaves the other bits unchanged.
- R4: A write to offset 0x08 clears to 0 each output bit whose written bit is 1, and leaves the other bits unchanged.
- R5: A write to offset 0x0C inverts each output bit whose written bit is 1, and leaves the other bits unchanged.
- R6: Reads from offsets 0x04, 0x08 and 0x0C return 0.
- R7: Offset 0x14 is the read/write direction register. Bit n = 1 drives `pin_oe[n]` high, which makes pin n an output. Bit n = 0 makes pin n an input.
- R8: Offset 0x10 returns the pin level as it was two rising clock edges before the read, when port-enable is high. A pin change applied before edge k is visible after edge k+1 and not after edge k. Writes to 0x10 have no effect.
- R9: An input bit whose `dig_mask` bit is 0 reads 0, whatever level its pin has.
- R10: While `port_en` is low, the input register holds its value. After `port_en` returns high, it follows the pins again with the R8 latency.
- R11: Writes to any other address, including misaligned addresses, change no register. Reads from such addresses return 0. `bus_rdata` is 0 whenever `bus_re` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| bus_addr | input | 8 | Byte address of the register |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_re | input | 1 | Read strobe |
| bus_rdata | output | 32 | Read data, combinational while `bus_re` is high |
| port_en | input | 1 | Enables updates of the input register |
| dig_mask | input | 32 | Per-pin digital-function enable for input sampling |
| pin_in | input | 32 | Pin levels from the pads |
| pin_out | output | 32 | Output latch driven to the pads |
| pin_oe | output | 32 | Per-pin output enable |

## Verification
A corrupt output latch shows on `pin_out` one edge after the faulty write. It also shows on the next read of offset 0x00, because a running reference model checks every write. Direction errors show on `pin_oe` in the same cycle. Sampler faults show up as three kinds of error on a read of 0x10. The first is a wrong latency, where the new level appears after one edge or only after three. The second is a masked bit that reads 1. The third is a value that moves while port-enable is low. An address decode error shows as a change to a register after a write to an unmapped or read-only address, or as a nonzero read from an alias or unmapped address.

// File: rtl/pio_pkg.sv
package pio_pkg;
  localparam int unsigned PIO_W = 32;
  localparam int unsigned PIO_AW = 8;

  localparam int unsigned OFS_DATA = 'h00;
  localparam int unsigned OFS_SET  = 'h04;
  localparam int unsigned OFS_CLR  = 'h08;
  localparam int unsigned OFS_TOG  = 'h0C;
  localparam int unsigned OFS_IN   = 'h10;
  localparam int unsigned OFS_DIR  = 'h14;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_DATA,
    SEL_SET,
    SEL_CLR,
    SEL_TOG,
    SEL_IN,
    SEL_DIR
  } pio_sel_e;
endpackage

// File: rtl/pio_decode.sv
module pio_decode
  import pio_pkg::*;
#(
  parameter int unsigned AW = PIO_AW
) (
  input  logic [AW-1:0] addr,
  output pio_sel_e      sel
);
  always_comb begin
    sel = SEL_NONE;
    if (addr == AW'(OFS_DATA))     sel = SEL_DATA;
    else if (addr == AW'(OFS_SET)) sel = SEL_SET;
    else if (addr == AW'(OFS_CLR)) sel = SEL_CLR;
    else if (addr == AW'(OFS_TOG)) sel = SEL_TOG;
    else if (addr == AW'(OFS_IN))  sel = SEL_IN;
    else if (addr == AW'(OFS_DIR)) sel = SEL_DIR;
  end
endmodule

// File: rtl/pio_out_regs.sv
module pio_out_regs
  import pio_pkg::*;
#(
  parameter int unsigned W = PIO_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         we,
  input  pio_sel_e     sel,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] data_q,
  output logic [W-1:0] dir_q
);
  logic [W-1:0] data_d;
  logic [W-1:0] dir_d;
  logic         data_en;
  logic         dir_en;

  always_comb begin
    data_en = 1'b0;
    data_d  = data_q;
    if (we) begin
      unique case (sel)
        SEL_DATA: begin data_en = 1'b1; data_d = wdata;           end
        SEL_SET:  begin data_en = 1'b1; data_d = data_q | wdata;  end
        SEL_CLR:  begin data_en = 1'b1; data_d = data_q & ~wdata; end
        SEL_TOG:  begin data_en = 1'b1; data_d = data_q ^ wdata;  end
        default:  begin data_en = 1'b0; data_d = data_q;          end
      endcase
    end
    dir_en = we && (sel == SEL_DIR);
    dir_d  = wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
      dir_q  <= '0;
    end else begin
      if (data_en) data_q <= data_d;
      if (dir_en)  dir_q  <= dir_d;
    end
  end
endmodule

// File: rtl/pio_in_sampler.sv
module pio_in_sampler #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic [W-1:0] pin_in,
  input  logic [W-1:0] mask,
  output logic [W-1:0] in_q
);
  for (genvar i = 0; i < W; i++) begin : g_pin
    logic meta_q;
    logic cap_d;

    always_comb cap_d = meta_q & mask[i];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        meta_q  <= 1'b0;
        in_q[i] <= 1'b0;
      end else begin
        meta_q <= pin_in[i];
        if (en) in_q[i] <= cap_d;
      end
    end
  end
endmodule

// File: rtl/pio_port.sv
module pio_port
  import pio_pkg::*;
#(
  parameter int unsigned W  = PIO_W,
  parameter int unsigned AW = PIO_AW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] bus_addr,
  input  logic          bus_we,
  input  logic [W-1:0]  bus_wdata,
  input  logic          bus_re,
  output logic [W-1:0]  bus_rdata,
  input  logic          port_en,
  input  logic [W-1:0]  dig_mask,
  input  logic [W-1:0]  pin_in,
  output logic [W-1:0]  pin_out,
  output logic [W-1:0]  pin_oe
);
  localparam int unsigned RST_STAGES = 2;

  logic [RST_STAGES-1:0] rst_pipe_q;
  logic                  rst_int_n;
  pio_sel_e              sel;
  logic [W-1:0]          data_q;
  logic [W-1:0]          dir_q;
  logic [W-1:0]          in_q;
  logic [W-1:0]          rd_mux;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= {rst_pipe_q[RST_STAGES-2:0], 1'b1};
  end
  assign rst_int_n = rst_pipe_q[RST_STAGES-1];

  pio_decode #(.AW(AW)) u_dec (
    .addr (bus_addr),
    .sel  (sel)
  );

  pio_out_regs #(.W(W)) u_out (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .we     (bus_we),
    .sel    (sel),
    .wdata  (bus_wdata),
    .data_q (data_q),
    .dir_q  (dir_q)
  );

  pio_in_sampler #(.W(W)) u_in (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .en     (port_en),
    .pin_in (pin_in),
    .mask   (dig_mask),
    .in_q   (in_q)
  );

  always_comb begin
    unique case (sel)
      SEL_DATA: rd_mux = data_q;
      SEL_IN:   rd_mux = in_q;
      SEL_DIR:  rd_mux = dir_q;
      default:  rd_mux = '0;
    endcase
    bus_rdata = bus_re ? rd_mux : '0;
  end

  assign pin_out = data_q;
  assign pin_oe  = dir_q;
endmodule

// File: rtl/pio_port_chk.sv
module pio_port_chk #(
  parameter int unsigned W  = 32,
  parameter int unsigned AW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic [AW-1:0] bus_addr,
  input logic          bus_we,
  input logic [W-1:0]  bus_wdata,
  input logic          bus_re,
  input logic [W-1:0]  bus_rdata,
  input logic          port_en,
  input logic [W-1:0]  pin_out,
  input logic [W-1:0]  pin_oe,
  input logic [W-1:0]  in_q
);
  logic wr_set, wr_clr, wr_tog, wr_data, wr_dir;
  assign wr_data = bus_we && (bus_addr == AW'('h00));
  assign wr_set  = bus_we && (bus_addr == AW'('h04));
  assign wr_clr  = bus_we && (bus_addr == AW'('h08));
  assign wr_tog  = bus_we && (bus_addr == AW'('h0C));
  assign wr_dir  = bus_we && (bus_addr == AW'('h14));

  // R3
  set_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_set |=> pin_out == ($past(pin_out) | $past(bus_wdata)));

  // R4
  clr_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_clr |=> pin_out == ($past(pin_out) & ~$past(bus_wdata)));

  // R5
  tog_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_tog |=> pin_out == ($past(pin_out) ^ $past(bus_wdata)));

  // R11
  out_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_data || wr_set || wr_clr || wr_tog) |=> $stable(pin_out));

  // R7
  oe_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_dir |=> $stable(pin_oe));

  // R6
  alias_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_re && (bus_addr == AW'('h04) || bus_addr == AW'('h08) ||
                bus_addr == AW'('h0C))) |-> bus_rdata == '0);

  // R10
  in_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !port_en |=> $stable(in_q));

  // R11
  idle_rdata_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_re |-> bus_rdata == '0);
endmodule

bind pio_port pio_port_chk #(.W(W), .AW(AW)) u_chk (.*);

// File: tb/sim_pio_port.sv
`timescale 1ns/1ps
module sim_pio_port;
  localparam int W = 32;
  localparam int AW = 8;

  logic          clk;
  logic          rst_n;
  logic [AW-1:0] bus_addr;
  logic          bus_we;
  logic [W-1:0]  bus_wdata;
  logic          bus_re;
  logic [W-1:0]  bus_rdata;
  logic          port_en;
  logic [W-1:0]  dig_mask;
  logic [W-1:0]  pin_in;
  logic [W-1:0]  pin_out;
  logic [W-1:0]  pin_oe;

  int n_tests = 0;
  int n_fail  = 0;
  bit finished = 0;
  logic [W-1:0] exp_out = '0;
  logic [W-1:0] exp_dir = '0;

  pio_port #(.W(W), .AW(AW)) u0 (.*);

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic logic [W-1:0] model_out(input logic [AW-1:0] a,
                                             input logic [W-1:0] q,
                                             input logic [W-1:0] w);
    case (a)
      8'h00:   return w;
      8'h04:   return q | w;
      8'h08:   return q & ~w;
      8'h0C:   return q ^ w;
      default: return q;
    endcase
  endfunction

  task automatic check(input string req, input logic [W-1:0] act,
                       input logic [W-1:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [W-1:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(posedge clk);
    #1 bus_we = 1'b0;
    exp_out = model_out(a, exp_out, d);
    if (a == 8'h14) exp_dir = d;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [W-1:0] d);
    @(negedge clk);
    bus_addr = a; bus_re = 1'b1;
    #1 d = bus_rdata;
    bus_re = 1'b0;
  endtask

  initial begin
    #2_000_000;
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog actual=%08h expected=%08h", 32'h0, 32'h1);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] r;
    logic [W-1:0] old_in;
    void'($urandom(32'h5EED_1234));
    rst_n = 1'b0; bus_addr = '0; bus_we = 1'b0; bus_wdata = '0; bus_re = 1'b0;
    port_en = 1'b0; dig_mask = '0; pin_in = '0;
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (4) @(posedge clk);

    // R1 reset state
    @(negedge clk);
    check("R1 pin_out", pin_out, '0);
    check("R1 pin_oe", pin_oe, '0);
    rd(8'h00, r); check("R1 data", r, '0);
    rd(8'h14, r); check("R1 dir", r, '0);
    rd(8'h10, r); check("R1 in", r, '0);
    check("R11 idle rdata", bus_rdata, '0);

    // R2 full replace
    wr(8'h00, 32'hA5A5_0F0F);
    @(negedge clk); check("R2 pin_out", pin_out, 32'hA5A5_0F0F);
    rd(8'h00, r); check("R2 readback", r, 32'hA5A5_0F0F);
    // R3 / R4 / R5 directed
    wr(8'h04, 32'h0000_00F0); rd(8'h00, r); check("R3 set", r, 32'hA5A5_0FFF);
    wr(8'h08, 32'hFFFF_0000); rd(8'h00, r); check("R4 clear", r, 32'h0000_0FFF);
    wr(8'h0C, 32'h8000_0F01); rd(8'h00, r); check("R5 toggle", r, 32'h8000_00FE);
    // R6 alias reads zero
    rd(8'h04, r); check("R6 set alias", r, '0);
    rd(8'h08, r); check("R6 clr alias", r, '0);
    rd(8'h0C, r); check("R6 tog alias", r, '0);
    // R7 direction
    wr(8'h14, 32'h1234_5678);
    @(negedge clk); check("R7 pin_oe", pin_oe, 32'h1234_5678);
    rd(8'h14, r); check("R7 readback", r, 32'h1234_5678);
    // R11 unmapped writes/reads
    wr(8'h18, 32'hFFFF_FFFF); wr(8'h02, 32'hFFFF_FFFF); wr(8'hFC, 32'hFFFF_FFFF);
    @(negedge clk);
    check("R11 out kept", pin_out, exp_out);
    check("R11 oe kept", pin_oe, exp_dir);
    rd(8'h18, r); check("R11 unmapped read", r, '0);
    rd(8'h16, r); check("R11 misaligned read", r, '0);

    // R8 latency
    @(negedge clk); port_en = 1'b1; dig_mask = '1; pin_in = 32'hDEAD_BEEF;
    @(posedge clk);
    rd(8'h10, r); check("R8 not after one edge", r, '0);
    @(posedge clk);
    rd(8'h10, r); check("R8 after two edges", r, 32'hDEAD_BEEF);
    // R8 write to input register ignored
    wr(8'h10, 32'h0000_0000);
    rd(8'h10, r); check("R8 write ignored", r, 32'hDEAD_BEEF);
    check("R8 out kept", pin_out, exp_out);
    // R9 mask
    @(negedge clk); dig_mask = 32'h0000_FFFF;
    repeat (2) @(posedge clk);
    rd(8'h10, r); check("R9 masked", r, 32'h0000_BEEF);
    // R10 hold
    @(negedge clk); dig_mask = '1; repeat (2) @(posedge clk);
    rd(8'h10, old_in);
    @(negedge clk); port_en = 1'b0; pin_in = 32'h0F0F_1234;
    repeat (5) @(posedge clk);
    rd(8'h10, r); check("R10 hold", r, old_in);
    @(negedge clk); port_en = 1'b1;
    repeat (2) @(posedge clk);
    rd(8'h10, r); check("R10 resume", r, 32'h0F0F_1234);

    // random mix over all write ops
    for (int i = 0; i < 400; i++) begin
      logic [AW-1:0] a;
      logic [W-1:0]  d;
      case ($urandom_range(0, 7))
        0: a = 8'h00; 1: a = 8'h04; 2: a = 8'h08; 3: a = 8'h0C;
        4: a = 8'h14; 5: a = 8'h10; 6: a = 8'h1C; default: a = 8'h05;
      endcase
      d = $urandom();
      wr(a, d);
      @(negedge clk);
      check("R2-R5 random pin_out", pin_out, exp_out);
      check("R7 random pin_oe", pin_oe, exp_dir);
      if (i % 8 == 0) begin
        rd(8'h00, r); check("R2 random readback", r, exp_out);
        rd(8'h14, r); check("R7 random readback", r, exp_dir);
      end
    end

    // random input sampling with mask
    for (int i = 0; i < 50; i++) begin
      logic [W-1:0] v;
      logic [W-1:0] m;
      v = $urandom(); m = $urandom();
      @(negedge clk); pin_in = v; dig_mask = m;
      repeat (2) @(posedge clk);
      rd(8'h10, r); check("R9 random sample", r, v & m);
    end

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule